// File: doc/BRIEF.md
# Two-Bar Separation Display for VGA

This block turns a small distance code into a picture. It produces a progressive 640x480 raster with separate horizontal and vertical sync and a three-bit colour output. On that raster it draws two upright bars. A red bar at a fixed column marks the transmitting object. A green bar marks the receiving object, and it moves to the right in equal steps, one step per 15 cm of separation. The largest step stands for 105 cm.

A distance estimator upstream presents a code and pulses a valid strobe when a new measurement is ready. The block keeps the most recent strobed code and copies it to the drawn position only on the last pixel of a frame, so one frame never shows the bar in two places. Codes larger than the top step are drawn at the top step. All raster sizes, bar geometry and the clocks-per-pixel ratio are parameters. The defaults give standard 60 Hz timing from a 50 MHz clock with a pixel every second cycle.

Top module: `relpos_bar_display`

## Requirements
- R1: `hsync_n` is low exactly for columns H_ACTIVE+H_FRONT through H_ACTIVE+H_FRONT+H_SYNC-1 of each line and high for all other columns. The column counter returns to 0 after H_ACTIVE+H_FRONT+H_SYNC+H_BACK-1.
- R2: `vsync_n` is low exactly for lines V_ACTIVE+V_FRONT through V_ACTIVE+V_FRONT+V_SYNC-1 and high on all other lines. It changes only at column 0.
- R3: `rgb` is 3'b000 whenever the column is at or beyond H_ACTIVE or the line is at or beyond V_ACTIVE.
- R4: The transmitter bar is red, `rgb` = 3'b100 (bit 2 red, bit 1 green, bit 0 blue). It covers columns TX_COL to TX_COL+BAR_W-1 on lines BAR_TOP to BAR_BOT, and it does not extend outside that range.
- R5: The receiver bar is green, `rgb` = 3'b010. It covers BAR_W columns starting at TX_COL+BAR_W+STEP_PX*code, on the same lines as the transmitter bar. For code 0 it sits directly against the transmitter bar. No pixel ever shows more than one colour bit.
- R6: A strobed `dist_code` greater than 2**CODE_W-1 (7 with the defaults, i.e. 105 cm) is stored as 2**CODE_W-1.
- R7: `dist_code` is sampled only in a cycle where `meas_valid` is high. At any other time its value has no effect on the picture.
- R8: A stored code becomes the drawn code at the transition into the next frame. Every pixel of the frame in which the strobe arrives still uses the previous code.
- R9: After reset the drawn code is 0 and the raster starts at column 0, line 0. During reset `hsync_n` and `vsync_n` are high and `rgb` is 0.
- R10: Active pixels that lie in neither bar are black (3'b000).
- R11: When several strobes arrive within one frame, the next frame draws the code of the last one.
- R12: The raster advances by one pixel every PIX_DIV clock cycles, counted from the first rising edge after reset is released. The pixel advances on the PIX_DIV-th such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_valid | input | 1 | One-cycle strobe: `dist_code` holds a new measurement |
| dist_code | input | CODE_IN_W | Separation in 15 cm steps, saturated to the top step |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 3 | Pixel colour: bit 2 red, bit 1 green, bit 0 blue |

## Verification
The bound checker looks at every cycle for the following:
- blanking of the colour output outside the visible area;
- the single-colour rule;
- saturation of oversized codes;
- the rule that the stored code moves only on a strobe and the drawn code only at the end of a frame;
- the column counter wrap;
- vsync edges that fall only at column 0.

Three properties depend on where things appear on the screen: the exact bar columns and rows, the adjacency at code 0, and the sync window boundaries. The bench shows these by sampling chosen pixels against its own raster model. The same model is needed to show that a strobe in mid-frame leaves the rest of that frame untouched, and that the last of several strobes wins.

// File: rtl/relpos_pkg.sv
package relpos_pkg;

  typedef enum logic [2:0] {
    PX_BLACK = 3'b000,
    PX_RED   = 3'b100,
    PX_GREEN = 3'b010
  } px_colour_e;

  // true when pos falls inside [lo, lo+width)
  function automatic logic in_span(int pos, int lo, int width);
    return (pos >= lo) && (pos < lo + width);
  endfunction

  // left column of the moving bar: it starts right after the fixed bar
  function automatic int rx_left_col(int tx_col, int bar_w, int step_px, int code);
    return tx_col + bar_w + step_px * code;
  endfunction

  function automatic int clamp_code(int raw, int max_code);
    return (raw > max_code) ? max_code : raw;
  endfunction

endpackage

// File: rtl/vga_pix_tick.sv
module vga_pix_tick #(
  parameter int PIX_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (PIX_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(PIX_DIV);
      localparam logic [DW-1:0] LAST = DW'(PIX_DIV - 1);
      logic [DW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/vga_scan_timer.sv
module vga_scan_timer #(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          active,
  output logic          frame_end
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACTIVE + H_FRONT);
  localparam logic [HW-1:0] HS_END = HW'(H_ACTIVE + H_FRONT + H_SYNC - 1);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACTIVE + V_FRONT);
  localparam logic [VW-1:0] VS_END = VW'(V_ACTIVE + V_FRONT + V_SYNC - 1);

  logic line_end;
  assign line_end  = tick && (h_pos == H_LAST);
  assign frame_end = line_end && (v_pos == V_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (tick) begin
      if (h_pos == H_LAST) begin
        h_pos <= '0;
        v_pos <= (v_pos == V_LAST) ? '0 : v_pos + 1'b1;
      end else begin
        h_pos <= h_pos + 1'b1;
      end
    end
  end

  assign hsync_n = !((h_pos >= HS_BEG) && (h_pos <= HS_END));
  assign vsync_n = !((v_pos >= VS_BEG) && (v_pos <= VS_END));
  assign active  = (h_pos < H_VIS) && (v_pos < V_VIS);
endmodule

// File: rtl/vga_code_latch.sv
module vga_code_latch
  import relpos_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int CODE_IN_W = 4,
  localparam int MAX_CODE = (1 << CODE_W) - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 meas_valid,
  input  logic [CODE_IN_W-1:0] dist_code,
  input  logic                 frame_end,
  output logic [CODE_W-1:0]    pend_code,
  output logic [CODE_W-1:0]    shown_code
);
  logic [CODE_W-1:0] clipped;
  assign clipped = CODE_W'(clamp_code(int'(dist_code), MAX_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_code  <= '0;
      shown_code <= '0;
    end else begin
      if (meas_valid) pend_code  <= clipped;
      if (frame_end)  shown_code <= pend_code;
    end
  end
endmodule

// File: rtl/vga_bar_painter.sv
module vga_bar_painter
  import relpos_pkg::*;
#(
  parameter int HW      = 10,
  parameter int VW      = 10,
  parameter int CODE_W  = 3,
  parameter int TX_COL  = 40,
  parameter int BAR_W   = 16,
  parameter int STEP_PX = 80,
  parameter int BAR_TOP = 100,
  parameter int BAR_BOT = 379
) (
  input  logic [HW-1:0]     h_pos,
  input  logic [VW-1:0]     v_pos,
  input  logic              active,
  input  logic [CODE_W-1:0] shown_code,
  output logic [2:0]        rgb
);
  localparam int BAR_H = BAR_BOT - BAR_TOP + 1;

  logic in_rows, on_tx, on_rx;
  assign in_rows = in_span(int'(v_pos), BAR_TOP, BAR_H);
  assign on_tx   = in_rows && in_span(int'(h_pos), TX_COL, BAR_W);
  assign on_rx   = in_rows && in_span(int'(h_pos),
                     rx_left_col(TX_COL, BAR_W, STEP_PX, int'(shown_code)), BAR_W);

  always_comb begin
    rgb = PX_BLACK;
    if (active) begin
      if (on_tx)      rgb = PX_RED;
      else if (on_rx) rgb = PX_GREEN;
    end
  end
endmodule

// File: rtl/relpos_bar_display.sv
module relpos_bar_display #(
  parameter int H_ACTIVE  = 640,
  parameter int H_FRONT   = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BACK    = 48,
  parameter int V_ACTIVE  = 480,
  parameter int V_FRONT   = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BACK    = 33,
  parameter int PIX_DIV   = 2,
  parameter int CODE_W    = 3,
  parameter int CODE_IN_W = 4,
  parameter int TX_COL    = 40,
  parameter int BAR_W     = 16,
  parameter int STEP_PX   = 80,
  parameter int BAR_TOP   = 100,
  parameter int BAR_BOT   = 379
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 meas_valid,
  input  logic [CODE_IN_W-1:0] dist_code,
  output logic                 hsync_n,
  output logic                 vsync_n,
  output logic [2:0]           rgb
);
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  // named internal events, also observed by the bound checker
  logic              pix_tick;
  logic [HW-1:0]     h_pos;
  logic [VW-1:0]     v_pos;
  logic              vis;
  logic              frame_end;
  logic [CODE_W-1:0] pend_code;
  logic [CODE_W-1:0] shown_code;

  vga_pix_tick #(.PIX_DIV(PIX_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(pix_tick)
  );

  vga_scan_timer #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .tick(pix_tick),
    .h_pos(h_pos), .v_pos(v_pos),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .active(vis), .frame_end(frame_end)
  );

  vga_code_latch #(.CODE_W(CODE_W), .CODE_IN_W(CODE_IN_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .meas_valid(meas_valid), .dist_code(dist_code),
    .frame_end(frame_end),
    .pend_code(pend_code), .shown_code(shown_code)
  );

  vga_bar_painter #(
    .HW(HW), .VW(VW), .CODE_W(CODE_W),
    .TX_COL(TX_COL), .BAR_W(BAR_W), .STEP_PX(STEP_PX),
    .BAR_TOP(BAR_TOP), .BAR_BOT(BAR_BOT)
  ) u_paint (
    .h_pos(h_pos), .v_pos(v_pos), .active(vis),
    .shown_code(shown_code), .rgb(rgb)
  );
endmodule

// File: rtl/relpos_bar_display_chk.sv
module relpos_bar_display_chk #(
  parameter int HW        = 10,
  parameter int H_TOTAL   = 800,
  parameter int CODE_W    = 3,
  parameter int CODE_IN_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 meas_valid,
  input logic [CODE_IN_W-1:0] dist_code,
  input logic                 vsync_n,
  input logic [2:0]           rgb,
  input logic                 pix_tick,
  input logic [HW-1:0]        h_pos,
  input logic                 vis,
  input logic                 frame_end,
  input logic [CODE_W-1:0]    pend_code,
  input logic [CODE_W-1:0]    shown_code
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [CODE_W-1:0] TOP_CODE = '1;
  localparam logic [CODE_IN_W-1:0] TOP_IN = CODE_IN_W'((1 << CODE_W) - 1);

  AST_HWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_tick && h_pos == H_LAST) |=> (h_pos == '0)); // R1
  AST_VSYNC_AT_COL0: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(vsync_n)) |-> (h_pos == '0)); // R2
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!vis) |-> (rgb == 3'b000)); // R3
  AST_ONE_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgb)); // R5
  AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && dist_code > TOP_IN) |=> (pend_code == TOP_CODE)); // R6
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_valid) |=> $stable(pend_code)); // R7
  AST_NO_TEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end) |=> $stable(shown_code)); // R8
endmodule

bind relpos_bar_display relpos_bar_display_chk #(
  .HW(HW), .H_TOTAL(H_TOTAL), .CODE_W(CODE_W), .CODE_IN_W(CODE_IN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .dist_code(dist_code),
  .vsync_n(vsync_n), .rgb(rgb), .pix_tick(pix_tick), .h_pos(h_pos),
  .vis(vis), .frame_end(frame_end), .pend_code(pend_code), .shown_code(shown_code)
);

// File: tb/relpos_bar_display_tb.sv
module relpos_bar_display_tb;
  // shrunken raster so that a frame is short
  localparam int HA = 64, HF = 4, HS = 8, HB = 4;
  localparam int VA = 40, VF = 2, VS = 2, VB = 4;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int DIV = 2;
  localparam int TXC = 4, BW = 2, STEP = 8, TOP = 10, BOT = 29;
  localparam logic [2:0] BLACK = 3'b000, RED = 3'b100, GREEN = 3'b010;

  // {strobed input code, code expected on screen}
  localparam logic [7:0] VEC [8] = '{
    {4'd3, 4'd3}, {4'd0, 4'd0}, {4'd7, 4'd7}, {4'd12, 4'd7},
    {4'd15, 4'd7}, {4'd1, 4'd1}, {4'd5, 4'd5}, {4'd2, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas_valid = 1'b0;
  logic [3:0] dist_code = 4'd0;
  logic hsync_n, vsync_n;
  logic [2:0] rgb;

  int ncyc = 0;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  relpos_bar_display #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .PIX_DIV(DIV), .CODE_W(3), .CODE_IN_W(4),
    .TX_COL(TXC), .BAR_W(BW), .STEP_PX(STEP), .BAR_TOP(TOP), .BAR_BOT(BOT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .dist_code(dist_code),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb)
  );

  function automatic int left_of(int code);
    return TXC + BW + code * STEP;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait (on falling edges) until the raster is at pixel (h,v) of frame f
  task automatic go_to(input int f, input int h, input int v);
    int target;
    target = f * HT * VT + v * HT + h;
    while (ncyc / DIV != target) @(negedge clk);
  endtask

  task automatic pix_is(input int f, input int h, input int v,
                        input logic [2:0] exp, input string req);
    go_to(f, h, v);
    check(rgb == exp, req, int'(rgb), int'(exp));
  endtask

  task automatic strobe(input logic [3:0] code);
    meas_valid = 1'b1;
    dist_code  = code;
    @(negedge clk);
    meas_valid = 1'b0;
    dist_code  = ~code;  // junk without a strobe
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cur;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(hsync_n == 1'b1, "R9 hsync in reset", int'(hsync_n), 1);
    check(vsync_n == 1'b1, "R9 vsync in reset", int'(vsync_n), 1);
    check(rgb == BLACK, "R9 rgb in reset", int'(rgb), 0);
    rst_n = 1'b1;
    // R12: after one edge the pixel has not moved
    @(negedge clk);
    check(rgb == BLACK && hsync_n, "R12 first pixel", int'(rgb), 0);

    // frame 0: sync windows and static geometry, drawn code 0
    pix_is(0, HA + 2, 5, BLACK, "R3 front porch");
    go_to(0, HA + HF - 1, 5);
    check(hsync_n == 1'b1, "R1 before sync", int'(hsync_n), 1);
    go_to(0, HA + HF, 5);
    check(hsync_n == 1'b0, "R1 sync start", int'(hsync_n), 0);
    go_to(0, HA + HF + HS - 1, 5);
    check(hsync_n == 1'b0, "R1 sync end", int'(hsync_n), 0);
    go_to(0, HA + HF + HS, 5);
    check(hsync_n == 1'b1, "R1 after sync", int'(hsync_n), 1);
    pix_is(0, TXC, TOP - 1, BLACK, "R4 above bar");
    pix_is(0, TXC - 1, TOP, BLACK, "R10 left of tx bar");
    pix_is(0, TXC, TOP, RED, "R4 tx bar top-left");
    pix_is(0, TXC + BW - 1, TOP, RED, "R4 tx bar right col");
    pix_is(0, left_of(0), TOP, GREEN, "R9 R5 rx bar at code 0 adjacent");
    pix_is(0, TXC, BOT, RED, "R4 tx bar bottom");
    pix_is(0, TXC, BOT + 1, BLACK, "R4 below bar");
    pix_is(0, 30, 35, BLACK, "R10 background");
    go_to(0, 0, VA + VF - 1);
    check(vsync_n == 1'b1, "R2 before vsync", int'(vsync_n), 1);
    go_to(0, 0, VA + VF);
    check(vsync_n == 1'b0, "R2 vsync start", int'(vsync_n), 0);
    check(rgb == BLACK, "R3 vertical blank", int'(rgb), 0);
    go_to(0, 0, VA + VF + VS);
    check(vsync_n == 1'b1, "R2 after vsync", int'(vsync_n), 1);

    // table walk: one frame per vector
    cur = 0;
    for (int i = 0; i < 8; i++) begin
      int f;
      int l;
      f = i + 1;
      l = left_of(cur);
      pix_is(f, l - 1, 12, (cur == 0) ? RED : BLACK, "R5 left of rx bar");
      pix_is(f, l, 12, GREEN, "R5 R6 R7 rx bar left col");
      pix_is(f, l + BW - 1, 12, GREEN, "R5 rx bar right col");
      pix_is(f, l + BW, 12, BLACK, "R5 R10 right of rx bar");
      go_to(f, 0, 20);
      strobe(VEC[i][7:4]);
      pix_is(f, l, 25, GREEN, "R8 old code kept mid-frame");
      cur = int'(VEC[i][3:0]);
    end

    // R11: last of two strobes in one frame wins
    pix_is(9, left_of(cur), 12, GREEN, "R6 final table code");
    go_to(9, 0, 20);
    strobe(4'd6);
    go_to(9, 0, 22);
    strobe(4'd4);
    pix_is(10, left_of(4), 12, GREEN, "R11 last strobe drawn");
    pix_is(10, left_of(6), 12, BLACK, "R11 earlier strobe discarded");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule